// File: doc/BRIEF.md
# Memoized XOR Result Cache

This block sits beside an ALU's XOR unit and remembers recent XOR results. A host presents two 8-bit operands with a request strobe. One cycle later the block returns their XOR together with a flag that says whether the answer came from a stored entry (hit) or from the direct datapath (miss). The answer is always correct. On a miss the directly computed result is written into the cache.

Before lookup, each operand pair is reduced to a canonical key, so that many different pairs share one entry. XOR ignores operand order, so the two canonical values are sorted with the smaller first. Every bit above the most significant set bit of A xor B is equal in both operands. Any such position that is set in both operands is cleared, because removing the same power of two from both operands leaves the XOR unchanged. When the two operands are equal, the key is (0,0). Eight fully associative entries hold canonical key, result and valid bit. When no entry is free, the least recently used one is replaced.

While the host holds the idle level high and makes no request, a background walker installs results for a sequence of operand pairs, one candidate per cycle. A host request always wins the shared lookup port.

Top module: `xor_memo_cache`

## Requirements
- R1: `req_ready` is always high, so there is no back-pressure. Every cycle with `req_valid` high is an accepted request, and `resp_valid` is high in exactly the following cycle. The response cannot be stalled.
- R2: In every response, `result` equals the bitwise XOR of the operands of the request it answers, on both hit and miss.
- R3: A request for (B,A) finds the entry installed or refreshed by (A,B), because the canonical key puts the smaller value first.
- R4: Let m be the most significant set bit of A xor B. The canonical key clears every bit above m in both operands. For example, (0xC5,0xC7), (0x81,0x83) and (0x05,0x07) all map to key (1,3). Equal operands map to (0,0).
- R5: A key absent from the cache gives a response with `hit` low and is then installed. Repeating the same key straight away gives `hit` high.
- R6: The cache has 8 entries. A miss fills the lowest-numbered free entry. When none is free, it replaces the entry whose last use (fill or hit) is oldest. A hit makes its entry the most recent.
- R7: The walker acts in each cycle with `idle` high and `req_valid` low. It starts from a counter value of 0 after reset, forms the pair (counter[7:4], counter[3:0]), canonicalizes it, installs it if the key is absent, and then advances the counter by one.
- R8: The walker does nothing in a cycle with `idle` low. In a cycle with `req_valid` high, the host request is served and the walker counter holds.
- R9: Synchronous active-high `rst` clears every valid bit, all ages and the walker counter, and drives `resp_valid` and `hit` low.
- R10: `hit` is high only in a cycle in which `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, operands valid |
| req_ready | output | 1 | Always high, requests are never refused |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| idle | input | 1 | Host idle level, enables the background walker |
| resp_valid | output | 1 | Response strobe, one cycle after a request |
| result | output | 8 | XOR of the requested operands |
| hit | output | 1 | Result was served from a stored entry |

## Verification
The swap and repeat properties assume that operands are stable and known whenever `req_valid` is high. They also assume that two requests in consecutive cycles have nothing between them that could evict the entry. This holds because the walker yields to the host and a single fill touches only one entry. The assertions treat `idle` as a plain level and expect `req_valid` low during reset. The stimulus drives all inputs at the falling edge and holds `req_valid` and `idle` low throughout reset. It pairs each sweep request with its swapped twin in the very next cycle, so the hit expectation rests only on the previous request.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  // Which agent owns the shared lookup port in a cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HOST = 2'd1,
    SRC_FILL = 2'd2
  } src_e;
endpackage

// File: rtl/xmc_canon.sv
// Canonical operand pair: bits above the top set bit of the XOR are
// cleared in both operands, then the pair is sorted ascending.
module xmc_canon #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] diff;
  logic [W-1:0] keep;
  logic [W-1:0] ca;
  logic [W-1:0] cb;

  assign diff = a ^ b;

  // A bit survives only if the operands differ somewhere at or above it.
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = |diff[W-1:i];
  end

  assign ca = a & keep;
  assign cb = b & keep;

  always_comb begin
    if (ca <= cb) begin
      lo = ca;
      hi = cb;
    end else begin
      lo = cb;
      hi = ca;
    end
  end
endmodule

// File: rtl/xmc_prefill.sv
// Background walker: a counter whose halves form the candidate pair.
module xmc_prefill #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] pa,
  output logic [W-1:0] pb
);
  localparam int LW = W - (W / 2);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign pa = W'(cnt[W-1:LW]);
  assign pb = W'(cnt[LW-1:0]);
endmodule

// File: rtl/xmc_tags.sv
// Fully associative store with per-entry age counters for LRU.
module xmc_tags #(
  parameter int W = 8,
  parameter int N = 8,
  localparam int KW = 2 * W,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] key,
  input  logic          touch_en,
  input  logic          fill_en,
  input  logic [W-1:0]  fill_data,
  output logic          hit,
  output logic [W-1:0]  hit_data
);
  logic [KW-1:0] tag_q [N];
  logic [W-1:0]  dat_q [N];
  logic [AW-1:0] age_q [N];
  logic [N-1:0]  vld_q;
  logic [N-1:0]  match;
  logic [AW-1:0] hit_idx;
  logic [AW-1:0] vic;
  logic [AW-1:0] best_age;
  logic          free_found;
  logic          upd;
  logic [AW-1:0] tidx;
  logic [AW-1:0] rage;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = vld_q[g] && (tag_q[g] == key);
  end

  assign hit = |match;

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (match[k]) hit_idx = AW'(k);
    end
  end

  assign hit_data = dat_q[hit_idx];

  // Victim: lowest free entry, otherwise the oldest valid entry.
  always_comb begin
    vic        = '0;
    best_age   = '0;
    free_found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!vld_q[k] && !free_found) begin
        vic        = AW'(k);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int k = 0; k < N; k++) begin
        if (age_q[k] >= best_age) begin
          best_age = age_q[k];
          vic      = AW'(k);
        end
      end
    end
  end

  assign upd  = fill_en | (touch_en & hit);
  assign tidx = fill_en ? vic : hit_idx;
  // A free victim counts as older than every valid entry.
  assign rage = fill_en ? (vld_q[vic] ? age_q[vic] : AW'(N - 1)) : age_q[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int k = 0; k < N; k++) age_q[k] <= '0;
    end else begin
      if (upd) begin
        for (int k = 0; k < N; k++) begin
          if (AW'(k) == tidx)                    age_q[k] <= '0;
          else if (vld_q[k] && age_q[k] < rage)  age_q[k] <= age_q[k] + 1'b1;
        end
      end
      if (fill_en) vld_q[vic] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[vic] <= key;
      dat_q[vic] <= fill_data;
    end
  end
endmodule

// File: rtl/xor_memo_cache.sv
module xor_memo_cache
  import xmc_pkg::*;
#(
  parameter int W = 8,
  parameter int N = 8,
  localparam int KW = 2 * W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         idle,
  output logic         resp_valid,
  output logic [W-1:0] result,
  output logic         hit
);
  src_e          src;
  logic [W-1:0]  h_lo, h_hi;
  logic [W-1:0]  f_a, f_b, f_lo, f_hi;
  logic [W-1:0]  pf_cnt;
  logic [KW-1:0] key;
  logic [W-1:0]  direct;
  logic          t_hit;
  logic [W-1:0]  t_data;
  logic          fill_en;

  assign req_ready = 1'b1;

  // The host always wins the single lookup port.
  always_comb begin
    if (req_valid)  src = SRC_HOST;
    else if (idle)  src = SRC_FILL;
    else            src = SRC_NONE;
  end

  xmc_canon #(.W(W)) u_host_canon (.a(op_a), .b(op_b), .lo(h_lo), .hi(h_hi));

  xmc_prefill #(.W(W)) u_pf (
    .clk (clk),
    .rst (rst),
    .step(src == SRC_FILL),
    .cnt (pf_cnt),
    .pa  (f_a),
    .pb  (f_b)
  );

  xmc_canon #(.W(W)) u_fill_canon (.a(f_a), .b(f_b), .lo(f_lo), .hi(f_hi));

  assign key     = (src == SRC_HOST) ? {h_lo, h_hi} : {f_lo, f_hi};
  assign direct  = (src == SRC_HOST) ? (op_a ^ op_b) : (f_a ^ f_b);
  assign fill_en = (src != SRC_NONE) && !t_hit;

  xmc_tags #(.W(W), .N(N)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .key      (key),
    .touch_en (src == SRC_HOST),
    .fill_en  (fill_en),
    .fill_data(direct),
    .hit      (t_hit),
    .hit_data (t_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      hit        <= 1'b0;
      result     <= '0;
    end else begin
      resp_valid <= (src == SRC_HOST);
      hit        <= (src == SRC_HOST) && t_hit;
      if (src == SRC_HOST) result <= t_hit ? t_data : direct;
    end
  end

  // Walker counter is observed only by the bound checker.
  logic unused_cnt;
  assign unused_cnt = ^pf_cnt;
endmodule

// File: rtl/xor_memo_cache_chk.sv
module xor_memo_cache_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         idle,
  input logic         resp_valid,
  input logic [W-1:0] result,
  input logic         hit,
  input logic [W-1:0] pf_cnt
);
  logic armed;
  logic rst_q;

  always_ff @(posedge clk) begin
    armed <= !rst;
    rst_q <= rst;
  end

  p_resp_latency_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> (resp_valid == $past(req_valid)));

  p_result_xor_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && req_valid) |=> (result == $past(op_a ^ op_b)));

  p_swap_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && req_valid && $past(req_valid) &&
     op_a == $past(op_b) && op_b == $past(op_a)) |=> hit);

  p_repeat_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && req_valid && $past(req_valid) &&
     op_a == $past(op_a) && op_b == $past(op_b)) |=> hit);

  p_walk_step_r7: assert property (@(posedge clk) disable iff (rst)
    (idle && !req_valid) |=> (pf_cnt == $past(pf_cnt) + 1'b1));

  p_walk_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid || !idle) |=> $stable(pf_cnt));

  p_hit_qual_r10: assert property (@(posedge clk) disable iff (rst)
    hit |-> resp_valid);

  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_clear_r9: assert (!resp_valid && !hit)
        else $error("outputs not cleared by reset");
    end
  end
endmodule

bind xor_memo_cache xor_memo_cache_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .idle      (idle),
  .resp_valid(resp_valid),
  .result    (result),
  .hit       (hit),
  .pf_cnt    (u_pf.cnt)
);

// File: tb/xor_memo_cache_tb.sv
module xor_memo_cache_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] op_a, op_b;
  logic       idle;
  logic       resp_valid;
  logic [7:0] result;
  logic       hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  xor_memo_cache u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .op_a(op_a), .op_b(op_b), .idle(idle),
    .resp_valid(resp_valid), .result(result), .hit(hit)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; idle = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  // want_hit: 0 or 1 checks the flag, -1 skips it.
  task automatic do_req(input logic [7:0] a, input logic [7:0] b,
                        input int want_hit, input string rq);
    op_a = a; op_b = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid === 1'b1, "R1 resp_valid", int'(resp_valid), 1);
    chk(result === (a ^ b), "R2 result", int'(result), int'(a ^ b));
    if (want_hit >= 0)
      chk(hit === want_hit[0], rq, int'(hit), want_hit);
  endtask

  initial begin
    do_reset();
    // R9: reset state
    chk(resp_valid === 1'b0, "R9 resp_valid after reset", int'(resp_valid), 0);
    chk(hit === 1'b0, "R9 hit after reset", int'(hit), 0);
    chk(req_ready === 1'b1, "R1 req_ready", int'(req_ready), 1);

    // R5: first access misses, repeat hits
    do_req(8'h12, 8'h34, 0, "R5 first miss");
    do_req(8'h12, 8'h34, 1, "R5 repeat hit");
    // R3: swapped operands share the entry
    do_req(8'h34, 8'h12, 1, "R3 swap hit");
    // R1, R10: idle cycle, no response and no hit
    @(negedge clk);
    chk(resp_valid === 1'b0, "R1 no request no response", int'(resp_valid), 0);
    chk(hit === 1'b0, "R10 hit without response", int'(hit), 0);

    // R4: shared high bits cleared
    do_req(8'hC5, 8'hC7, 0, "R4 key (1,3) miss");
    do_req(8'h05, 8'h07, 1, "R4 shared bits hit");
    do_req(8'h83, 8'h81, 1, "R4 shared bits swapped hit");
    do_req(8'h45, 8'h07, 0, "R4 different prefix miss");
    do_req(8'h33, 8'h33, 0, "R4 equal operands miss");
    do_req(8'hAA, 8'hAA, 1, "R4 equal operands hit");

    // R9: reset forgets entries
    do_reset();
    do_req(8'h12, 8'h34, 0, "R9 entry cleared by reset");

    // R6: LRU replacement with keys (0,1)..(0,8)
    do_reset();
    for (int k = 1; k <= 8; k++) do_req(8'h00, 8'(k), 0, "R6 fill miss");
    do_req(8'h01, 8'h00, 1, "R6 refresh hit");
    do_req(8'h00, 8'h09, 0, "R6 ninth key miss");
    do_req(8'h00, 8'h02, 0, "R6 oldest evicted");
    do_req(8'h00, 8'h01, 1, "R6 refreshed entry kept");
    do_req(8'h00, 8'h03, 0, "R6 next oldest evicted");
    do_req(8'h00, 8'h09, 1, "R6 recent fill kept");

    // R7: three idle cycles install (0,0),(0,1),(0,2)
    do_reset();
    idle = 1'b1;
    repeat (3) @(negedge clk);
    idle = 1'b0;
    do_req(8'h02, 8'h00, 1, "R7 walker installed (0,2)");
    do_req(8'h00, 8'h00, 1, "R7 walker installed (0,0)");
    do_req(8'h01, 8'h00, 1, "R7 walker installed (0,1)");
    do_req(8'h00, 8'h03, 0, "R8 walker stopped when idle low");

    // R8: host requests hold the walker
    do_reset();
    idle = 1'b1;
    do_req(8'h00, 8'h05, 0, "R8 host wins over walker");
    do_req(8'h00, 8'h06, 0, "R8 host wins over walker");
    @(negedge clk);  // one walker step: counter 0 -> pair (0,0)
    idle = 1'b0;
    do_req(8'h00, 8'h00, 1, "R8 walker resumed at count 0");
    do_req(8'h00, 8'h01, 0, "R8 counter held during requests");

    // R2, R3: sweep of all operand pairs, each followed by its swap
    do_reset();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        do_req(8'(a), 8'(b), -1, "R2 sweep");
        do_req(8'(b), 8'(a), 1, "R3 sweep swap hit");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule